// File: doc/BRIEF.md
# Byte-Enabled Parallel CRC-32 Engine

This block computes a 32-bit frame check sequence over a byte stream delivered 32 bits per clock, where any word may carry one, two, three or four valid bytes. Each accepted word passes through an input register that also selects and masks the valid byte lanes. A parallel update stage then folds up to four bytes into the running remainder in one cycle, and an output register presents the result. A start-of-frame marker reloads the preset. An end-of-frame marker tags the word that completes the frame, so the value shown with it is the final check sequence.

The remainder uses the bit-reflected form of generator 0x04C11DB7 (shift constant 0xEDB88320). It starts at all ones and is complemented on output. On the receive side, the stream can include the transmitted check bytes. The block then raises a pass flag when the remainder after the last byte equals the fixed residue 0xDEBB20E3. A single `ready` input freezes the whole pipeline, so every stage holds its contents while the downstream side applies backpressure.

Top module: `crc32_byte_engine`

## Requirements
- R1: While `rst_n` is low, and until the first accepted word has reached the output, `out_valid`, `out_last` and `out_check` are 0 and `crc_out` is 0x00000000.
- R2: Bytes are processed in lane order: lane 0 (`in_data[7:0]`) first, then bits 15:8, 23:16 and 31:24. The remainder uses the reflected polynomial 0xEDB88320, is preset to 0xFFFFFFFF and is complemented on output. The ASCII string "123456789" yields 0xCBF43926.
- R3: `in_cnt` selects the valid byte count: 00 means 1 byte, 01 means 2, 10 means 3 and 11 means 4. Only the lowest lanes are valid. Bytes in lanes above the count have no effect on the result.
- R4: A word accepted with `in_sof` high starts from the preset value, whatever the remainder held before, including in the middle of an unfinished frame.
- R5: A word accepted at rising edge k appears on the outputs after edge k+2. `out_valid` is high for that one cycle, and `out_last` copies the word's end-of-frame marker.
- R6: While `ready` is low, no input is accepted and `crc_out`, `out_valid`, `out_last` and `out_check` hold their values. The frame result is unaffected by a stall, even when the input bus carries other data during it.
- R7: A cycle with `in_valid` low leaves the remainder unchanged, whatever `in_sof`, `in_eof`, `in_cnt` and `in_data` carry.
- R8: `out_check` is 1 only together with `out_valid` and `out_last`, and only when the remainder before complementing equals 0xDEBB20E3.
- R9: After every accepted word, `crc_out` shows the complemented running remainder over all bytes of the frame so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 32 | Data word, lane 0 in bits 7:0 |
| in_cnt | input | 2 | Valid byte count minus one |
| in_valid | input | 1 | Word strobe |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| ready | input | 1 | Downstream ready; low freezes the pipeline |
| crc_out | output | 32 | Complemented running or final remainder |
| out_valid | output | 1 | A word's result is shown this cycle |
| out_last | output | 1 | The shown result completes a frame |
| out_check | output | 1 | Receive residue matched on the last word |

## Verification
Two things can happen to the same word at once: the reload on start-of-frame and the final result on end-of-frame. A one-word frame carries both markers. A restart is also sent in the middle of an unfinished frame, and the value shown must ignore the abandoned bytes. A stall can land in the middle of a frame while other data sits on the input bus. It is judged by checking that the outputs stay frozen, and that the remainder and residue flag are correct after the frame completes.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 32;

    // Fold one byte into a reflected remainder, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_byte(
        input logic [CRC_W-1:0]  rem,
        input logic [BYTE_W-1:0] b,
        input logic [CRC_W-1:0]  poly_rev
    );
        logic [CRC_W-1:0] r;
        r = rem ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[0] ? ((r >> 1) ^ poly_rev) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_lane_select.sv
module crc_lane_select
    import crc32_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ready,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic                    in_eof,
    input  logic [CNT_W-1:0]        in_cnt,
    input  logic [LANES*BYTE_W-1:0] in_data,
    output logic                    s1_valid,
    output logic                    s1_sof,
    output logic                    s1_eof,
    output logic [LANES-1:0]        s1_mask,
    output logic [LANES*BYTE_W-1:0] s1_data
);

    typedef struct packed {
        logic                    valid;
        logic                    sof;
        logic                    eof;
        logic [LANES-1:0]        mask;
        logic [LANES*BYTE_W-1:0] data;
    } sel_t;

    sel_t                    st_d, st_q;
    logic [LANES-1:0]        lane_en;
    logic [LANES*BYTE_W-1:0] lane_byte;

    // Per-lane enable and byte placement into processing order.
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        assign lane_en[gi] = in_valid && (int'(in_cnt) >= gi);
        assign lane_byte[gi*BYTE_W +: BYTE_W] =
            lane_en[gi] ? in_data[gi*BYTE_W +: BYTE_W] : '0;
    end

    always_comb begin
        st_d = st_q;
        if (ready) begin
            st_d.valid = in_valid;
            st_d.sof   = in_valid && in_sof;
            st_d.eof   = in_valid && in_eof;
            st_d.mask  = lane_en;
            st_d.data  = lane_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_valid = st_q.valid;
    assign s1_sof   = st_q.sof;
    assign s1_eof   = st_q.eof;
    assign s1_mask  = st_q.mask;
    assign s1_data  = st_q.data;

    // R6: the input register is frozen while ready is low.
    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(st_q));

    // R3: valid lanes form a contiguous run starting at lane 0.
    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $onehot({1'b0, s1_mask} + 1'b1));

endmodule

// File: rtl/crc_matrix.sv
module crc_matrix
    import crc32_pkg::*;
#(
    parameter int               LANES    = 4,
    parameter logic [CRC_W-1:0] POLY_REV = 32'hEDB88320,
    parameter logic [CRC_W-1:0] INIT     = 32'hFFFFFFFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ready,
    input  logic                    s1_valid,
    input  logic                    s1_sof,
    input  logic                    s1_eof,
    input  logic [LANES-1:0]        s1_mask,
    input  logic [LANES*BYTE_W-1:0] s1_data,
    output logic [CRC_W-1:0]        rem_q,
    output logic                    s2_valid,
    output logic                    s2_eof
);

    typedef struct packed {
        logic [CRC_W-1:0] rem;
        logic             valid;
        logic             eof;
    } mat_t;

    mat_t             m_d, m_q;
    logic [CRC_W-1:0] calc;

    always_comb begin
        calc = s1_sof ? INIT : m_q.rem;
        for (int i = 0; i < LANES; i++) begin
            if (s1_mask[i]) calc = crc_byte(calc, s1_data[i*BYTE_W +: BYTE_W], POLY_REV);
        end
        m_d = m_q;
        if (ready) begin
            m_d.valid = s1_valid;
            m_d.eof   = s1_eof;
            if (s1_valid) m_d.rem = calc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{rem: INIT, valid: 1'b0, eof: 1'b0};
        else        m_q <= m_d;
    end

    assign rem_q    = m_q.rem;
    assign s2_valid = m_q.valid;
    assign s2_eof   = m_q.eof;

    // R7: an empty slot leaves the remainder untouched.
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !s1_valid) |=> $stable(rem_q));

endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine
    import crc32_pkg::*;
#(
    parameter int               DATA_W   = 32,
    parameter logic [CRC_W-1:0] POLY_REV = 32'hEDB88320,
    parameter logic [CRC_W-1:0] INIT     = 32'hFFFFFFFF,
    parameter logic [CRC_W-1:0] XOR_OUT  = 32'hFFFFFFFF,
    parameter logic [CRC_W-1:0] RESIDUE  = 32'hDEBB20E3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [DATA_W-1:0]                  in_data,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0]   in_cnt,
    input  logic                               in_valid,
    input  logic                               in_sof,
    input  logic                               in_eof,
    input  logic                               ready,
    output logic [CRC_W-1:0]                   crc_out,
    output logic                               out_valid,
    output logic                               out_last,
    output logic                               out_check
);

    localparam int LANES = DATA_W / BYTE_W;
    localparam int CNT_W = $clog2(LANES);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             valid;
        logic             last;
        logic             check;
    } out_t;

    logic                    s1_valid, s1_sof, s1_eof;
    logic [LANES-1:0]        s1_mask;
    logic [DATA_W-1:0]       s1_data;
    logic [CRC_W-1:0]        rem_q;
    logic                    s2_valid, s2_eof;
    out_t                    o_d, o_q;

    crc_lane_select #(.LANES(LANES), .CNT_W(CNT_W)) u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (ready),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_cnt   (in_cnt),
        .in_data  (in_data),
        .s1_valid (s1_valid),
        .s1_sof   (s1_sof),
        .s1_eof   (s1_eof),
        .s1_mask  (s1_mask),
        .s1_data  (s1_data)
    );

    crc_matrix #(.LANES(LANES), .POLY_REV(POLY_REV), .INIT(INIT)) u_matrix (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (ready),
        .s1_valid (s1_valid),
        .s1_sof   (s1_sof),
        .s1_eof   (s1_eof),
        .s1_mask  (s1_mask),
        .s1_data  (s1_data),
        .rem_q    (rem_q),
        .s2_valid (s2_valid),
        .s2_eof   (s2_eof)
    );

    // Output buffer: complement, residue compare, marker alignment.
    always_comb begin
        o_d = o_q;
        if (ready) begin
            o_d.crc   = rem_q ^ XOR_OUT;
            o_d.valid = s2_valid;
            o_d.last  = s2_valid && s2_eof;
            o_d.check = s2_valid && s2_eof && (rem_q == RESIDUE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign crc_out   = o_q.crc;
    assign out_valid = o_q.valid;
    assign out_last  = o_q.last;
    assign out_check = o_q.check;

    // R6: outputs are frozen across a stalled cycle.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(crc_out) && $stable(out_valid)
                    && $stable(out_last) && $stable(out_check)));

    // R8: the pass flag only accompanies a shown last word.
    p_check_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_check |-> (out_valid && out_last));

endmodule

// File: tb/tb_crc32_byte_engine.sv
`timescale 1ns/1ps
module tb_crc32_byte_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_cnt = '0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, ready = 1'b1;
    logic [31:0] crc_out;
    logic        out_valid, out_last, out_check;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model = 32'hFFFFFFFF;

    always #2 clk = ~clk;

    crc32_byte_engine dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_cnt(in_cnt),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .ready(ready),
        .crc_out(crc_out), .out_valid(out_valid), .out_last(out_last),
        .out_check(out_check)
    );

    // {sof, eof, cnt[1:0], data[31:0]}
    localparam int NV = 9;
    localparam logic [35:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'b11, 32'h34333231},
        {1'b0, 1'b0, 2'b11, 32'h38373635},
        {1'b0, 1'b1, 2'b00, 32'hAABBCC39},
        {1'b1, 1'b1, 2'b01, 32'h77665A7E},
        {1'b1, 1'b0, 2'b10, 32'hFF7D7E00},
        {1'b0, 1'b0, 2'b00, 32'h123456C3},
        {1'b0, 1'b1, 2'b11, 32'h0F1E2D3C},
        {1'b1, 1'b0, 2'b11, 32'hDEADBEEF},
        {1'b1, 1'b1, 2'b00, 32'h99999900}
    };

    function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic model_word(input logic sof, input logic [1:0] cnt, input logic [31:0] d);
        if (sof) model = 32'hFFFFFFFF;
        for (int n = 0; n <= int'(cnt); n++) model = ref_byte(model, d[n*8 +: 8]);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one word at a falling edge; leave misleading idle values behind it.
    task automatic push(input logic sof, input logic eof, input logic [1:0] cnt, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_eof = eof; in_cnt = cnt; in_data = d;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_cnt = 2'b11; in_data = 32'hDEAD7E7D;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 crc_out in reset", crc_out, 32'h0);
        chk("R1 out_valid in reset", {31'h0, out_valid}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 flags after reset", {29'h0, out_valid, out_last, out_check}, 32'h0);
        chk("R1 crc_out after reset", crc_out, 32'h0);

        // Vector table: R2 R3 R4 R5 R7 R9
        for (int i = 0; i < NV; i++) begin
            logic [35:0] v;
            v = VEC[i];
            push(v[35], v[34], v[33:32], v[31:0]);
            model_word(v[35], v[33:32], v[31:0]);
            @(negedge clk);
            chk("R5 not yet valid after two edges", {31'h0, out_valid}, 32'h0);
            @(negedge clk);
            chk("R5 valid after three edges", {31'h0, out_valid}, 32'h1);
            chk("R5 last marker", {31'h0, out_last}, {31'h0, v[34]});
            chk("R9 running crc", crc_out, ~model);
            chk("R8 no false pass", {31'h0, out_check},
                {31'h0, v[34] && (model == 32'hDEBB20E3)});
            if (i == 2) chk("R2 known answer 123456789", crc_out, 32'hCBF43926);
            if (i == 2) chk("R3 upper lanes ignored", crc_out, 32'hCBF43926);
        end

        // R4: restart in the middle of an unfinished frame, single-word frame
        push(1'b1, 1'b0, 2'b11, 32'h11223344);
        push(1'b1, 1'b1, 2'b11, 32'h34333231);
        repeat (2) @(negedge clk);
        model = 32'hFFFFFFFF;
        model_word(1'b0, 2'b11, 32'h34333231);
        chk("R4 restart discards earlier bytes", crc_out, ~model);

        // R8: receive frame with correct check bytes
        push(1'b1, 1'b0, 2'b11, 32'h34333231);
        push(1'b0, 1'b0, 2'b11, 32'h38373635);
        push(1'b0, 1'b0, 2'b11, 32'hF4392639);
        push(1'b0, 1'b1, 2'b00, 32'h000000CB);
        repeat (2) @(negedge clk);
        chk("R8 residue pass", {31'h0, out_check}, 32'h1);
        chk("R8 residue crc_out", crc_out, 32'h2144DF1C);

        // R8: corrupted check byte
        push(1'b1, 1'b0, 2'b11, 32'h34333231);
        push(1'b0, 1'b0, 2'b11, 32'h38373635);
        push(1'b0, 1'b0, 2'b11, 32'hF4392639);
        push(1'b0, 1'b1, 2'b00, 32'h000000CA);
        repeat (2) @(negedge clk);
        chk("R8 residue fail", {31'h0, out_check}, 32'h0);
        chk("R8 last without pass", {31'h0, out_last}, 32'h1);

        // R6: back-to-back stream with a stall and garbage on the bus
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0; in_cnt = 2'b11; in_data = 32'h34333231;
        @(negedge clk);
        in_sof = 1'b0; in_data = 32'h38373635;
        @(negedge clk);
        ready = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_cnt = 2'b01; in_data = 32'h5555AAAA;
        begin
            logic [31:0] held;
            logic [2:0]  hflags;
            @(negedge clk);
            held = crc_out;
            hflags = {out_valid, out_last, out_check};
            repeat (3) @(negedge clk);
            chk("R6 crc_out held", crc_out, held);
            chk("R6 flags held", {29'h0, out_valid, out_last, out_check}, {29'h0, hflags});
        end
        in_sof = 1'b0; in_eof = 1'b0; in_cnt = 2'b11; in_data = 32'hF4392639;
        ready = 1'b1;
        @(negedge clk);
        in_eof = 1'b1; in_cnt = 2'b00; in_data = 32'h000000CB;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 result after stall", crc_out, 32'h2144DF1C);
        chk("R6 pass after stall", {31'h0, out_check}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule